// File: doc/BRIEF.md
# Watchdog Timer with Reset-Cause Flags

The block is a watchdog that counts rising edges on one tap of a free-running prescaler. It offers one 8-bit control/status register. Software picks one of four timeout intervals with a 2-bit select. The first write of a zero to the enable bit starts the watchdog, and every later zero write restarts its count. Once started, the watchdog cannot be stopped. A static configuration input chooses the pacing source: the main clock, or a sub-clock supplied as a one-cycle enable strobe (`sub_tick`) synchronous to `clk`.

When the count runs out, the block pulses a one-cycle reset request. The same register keeps sticky flags that record why the chip was last reset: power-on, watchdog expiry, the external reset pin, or a software reset. The chip-level reset logic reports the external and software events on `ext_rst` and `sw_rst`. Any reset other than power-on stops the watchdog and returns the interval select to its reset value. The next zero write then counts as a start again.

The watchdog counter counts eight tap edges. Expiry therefore lands between 7 and 8 tap periods after the start or restart write. This always falls inside the nominal interval ±1/8. Parameter `PRESCALE_SHIFT` moves every tap down by that many bits, which lets a short simulation exercise the timing.

Top module: `wdt_rstcause`

## Requirements
- R1: Register layout as seen on `rdata`:
  - bit 7 is the power-on flag.
  - bit 6 always reads 0.
  - bit 5 is the watchdog-reset flag.
  - bit 4 is the external-reset flag.
  - bit 3 is the software-reset flag.
  - bits 2:0 are write-only (bit 2 = enable/clear, bits 1:0 = interval select) and read back as 1.
- R2: After power-on reset (`por_n` low), `rdata` reads 8'h87. The watchdog is stopped, `wdt_req` is 0 and the interval select is 2'b11.
- R3: A write with bit 2 = 0 has two cases:
  - while the watchdog is stopped, it starts the watchdog.
  - while it is running, it restarts the count, and the next expiry is timed from that write.
  - A write with bit 2 = 1 never starts, restarts or stops the watchdog.
- R4: With `use_sub` = 0, select values 0, 1, 2, 3 give a tap period P of 2^(11-S), 2^(13-S), 2^(15-S), 2^(18-S) clock cycles, where S = `PRESCALE_SHIFT`. `wdt_req` rises between 7P+1 and 8P cycles after the start or restart write edge.
- R5: With `use_sub` = 1, select values 0, 1, 2, 3 give P = 2^(9-S), 2^(12-S), 2^(13-S), 2^(14-S) sub-clock ticks. Expiry falls in the same 7P..8P window, measured in ticks.
- R6: On expiry:
  - `wdt_req` is high for exactly one cycle.
  - bit 5 reads 1 from that same cycle onward.
  - the watchdog stops and needs a new start write.
- R7: The interval select is taken from a write only while the watchdog is stopped. Select bits written while it runs are ignored.
- R8: While stopped, the watchdog never raises `wdt_req`.
- R9: An `ext_rst` pulse sets bit 4 on the next cycle and stops the watchdog, so there is no `wdt_req` afterwards. The other cause bits keep their values.
- R10: An `sw_rst` pulse sets bit 3 on the next cycle and stops the watchdog. If `ext_rst` and `sw_rst` arrive in the same cycle, both flags are set.
- R11: Cause flags are never cleared except by power-on reset, and a power-on reset overrides any other cause present at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sub_tick | input | 1 | One-cycle strobe per sub-clock period |
| use_sub | input | 1 | 1 = sub-clock paces the timeout |
| ext_rst | input | 1 | External reset pin event, one-cycle pulse |
| sw_rst | input | 1 | Software reset event, one-cycle pulse |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 3 | Write data: bit 2 enable/clear, bits 1:0 interval |
| rdata | output | 8 | Register read value |
| wdt_req | output | 1 | Watchdog reset request, one-cycle pulse |

## Verification
A write is captured at the rising edge that sees `wr_en`. Cause flags from `ext_rst` and `sw_rst` show up on `rdata` one edge after the strobe, and bit 5 rises on the same edge as `wdt_req`. Expiry is due 7P+1 to 8P cycles (or tick-scaled cycles) after the start or restart edge. The bench drives all inputs and samples on falling edges, and stamps times from a rising-edge cycle counter. It measures expiry as the difference between the stamp taken after the write edge and the stamp taken at the first falling edge where `wdt_req` is high. It then checks that difference against the window computed from the select value.

// File: rtl/wdt_rstcause.sv
module wdt_rstcause #(
  parameter int PRESCALE_SHIFT = 0
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       sub_tick,
  input  logic       use_sub,
  input  logic       ext_rst,
  input  logic       sw_rst,
  input  logic       wr_en,
  input  logic [2:0] wdata,
  output logic [7:0] rdata,
  output logic       wdt_req
);
  localparam int S      = PRESCALE_SHIFT;
  localparam int MAIN_W = 18 - S;
  localparam int SUB_W  = 14 - S;
  localparam int M0 = 10 - S, M1 = 12 - S, M2 = 14 - S, M3 = 17 - S;
  localparam int U0 = 8 - S,  U1 = 11 - S, U2 = 12 - S, U3 = 13 - S;

  logic [MAIN_W-1:0] pre_main;
  logic [SUB_W-1:0]  pre_sub;
  logic [3:0] main_taps, sub_taps, main_q, sub_q, main_edge, sub_edge;
  logic [1:0] wt;
  logic [2:0] cnt;
  logic       running, wrst, erst, srst;
  logic       tick, sys_rst, expire, wr_zero;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      pre_main <= '0;
      pre_sub  <= '0;
    end else begin
      pre_main <= pre_main + 1'b1;
      if (sub_tick) pre_sub <= pre_sub + 1'b1;
    end

  assign main_taps = {pre_main[M3], pre_main[M2], pre_main[M1], pre_main[M0]};
  assign sub_taps  = {pre_sub[U3],  pre_sub[U2],  pre_sub[U1],  pre_sub[U0]};

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      main_q <= '0;
      sub_q  <= '0;
    end else begin
      main_q <= main_taps;
      sub_q  <= sub_taps;
    end

  assign main_edge = main_taps & ~main_q;
  assign sub_edge  = sub_taps & ~sub_q;
  assign tick      = use_sub ? sub_edge[wt] : main_edge[wt];
  assign sys_rst   = ext_rst | sw_rst;
  assign expire    = running & tick & (cnt == 3'd7) & ~sys_rst;
  assign wr_zero   = wr_en & ~wdata[2];

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      running <= 1'b0;
      wt      <= 2'b11;
      cnt     <= 3'd0;
      wdt_req <= 1'b0;
      wrst    <= 1'b0;
      erst    <= 1'b0;
      srst    <= 1'b0;
    end else begin
      wdt_req <= expire;
      if (expire)  wrst <= 1'b1;
      if (ext_rst) erst <= 1'b1;
      if (sw_rst)  srst <= 1'b1;
      if (sys_rst | expire) begin
        running <= 1'b0;
        wt      <= 2'b11;
        cnt     <= 3'd0;
      end else if (wr_zero) begin
        running <= 1'b1;
        cnt     <= 3'd0;
        if (!running) wt <= wdata[1:0];
      end else if (wr_en && !running) begin
        wt <= wdata[1:0];
      end else if (running && tick) begin
        cnt <= cnt + 3'd1;
      end
    end

  assign rdata = {1'b1, 1'b0, wrst, erst, srst, 3'b111};
endmodule

// File: rtl/wdt_rstcause_chk.sv
module wdt_rstcause_chk (
  input logic       clk,
  input logic       por_n,
  input logic       ext_rst,
  input logic       sw_rst,
  input logic [7:0] rdata,
  input logic       wdt_req
);
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!por_n) wdt_req |=> !wdt_req); // R6
  AST_REQ_SETS_WRST: assert property (@(posedge clk) disable iff (!por_n) wdt_req |-> rdata[5]); // R6
  AST_EXT_FLAG: assert property (@(posedge clk) disable iff (!por_n) ext_rst |=> rdata[4]); // R9
  AST_SW_FLAG: assert property (@(posedge clk) disable iff (!por_n) sw_rst |=> rdata[3]); // R10
  AST_RST_STOPS: assert property (@(posedge clk) disable iff (!por_n) (ext_rst || sw_rst) |=> !wdt_req); // R9
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    !($fell(rdata[5]) || $fell(rdata[4]) || $fell(rdata[3]))); // R11
endmodule

bind wdt_rstcause wdt_rstcause_chk u_chk (
  .clk(clk), .por_n(por_n), .ext_rst(ext_rst), .sw_rst(sw_rst),
  .rdata(rdata), .wdt_req(wdt_req)
);

// File: tb/wdt_rstcause_bench.sv
module wdt_rstcause_bench;
  localparam int S = 7;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       sub_tick = 1'b0;
  logic       use_sub = 1'b0;
  logic       ext_rst = 1'b0;
  logic       sw_rst = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wdata = 3'b111;
  logic [7:0] rdata;
  logic       wdt_req;
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  wdt_rstcause #(.PRESCALE_SHIFT(S)) u_wdt_rstcause (
    .clk(clk), .por_n(por_n), .sub_tick(sub_tick), .use_sub(use_sub),
    .ext_rst(ext_rst), .sw_rst(sw_rst), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .wdt_req(wdt_req)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      sub_tick = 1'b1;
      @(negedge clk);
      sub_tick = 1'b0;
    end
  end

  function automatic int period(bit us, int w);
    int e;
    if (us) begin
      e = (w == 0) ? 12 : (w == 1) ? 15 : (w == 2) ? 16 : 17;
      return (1 << (e - 3 - S)) * 4;
    end
    e = (w == 0) ? 14 : (w == 1) ? 16 : (w == 2) ? 18 : 21;
    return 1 << (e - 3 - S);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] d, output int t);
    @(negedge clk);
    wr_en = 1'b1;
    wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    t = cyc;
  endtask

  task automatic wait_req(int limit, output int t);
    t = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (wdt_req) begin
        t = cyc;
        return;
      end
    end
  endtask

  task automatic expiry(bit us, int w, int t0, string tag);
    int t, p;
    p = period(us, w);
    wait_req(9 * p, t);
    chk(t >= 0 && (t - t0) >= 7 * p + 1 && (t - t0) <= 8 * p, tag, t - t0, 8 * p);
    chk(rdata[5] == 1'b1, "R6 watchdog flag set", rdata[5], 1);
    @(negedge clk);
    chk(wdt_req == 1'b0, "R6 request one cycle", wdt_req, 0);
  endtask

  task automatic quiet(int n, string tag);
    int t;
    wait_req(n, t);
    chk(t < 0, tag, t, -1);
  endtask

  task automatic pulse(bit e, bit s);
    @(negedge clk);
    ext_rst = e;
    sw_rst = s;
    @(negedge clk);
    ext_rst = 1'b0;
    sw_rst = 1'b0;
  endtask

  task automatic power_on;
    @(negedge clk);
    por_n = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int t0, t1;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    chk(rdata == 8'h87, "R1 R2 reset value", rdata, 8'h87);
    chk(wdt_req == 1'b0, "R2 no request at reset", wdt_req, 0);
    quiet(300, "R2 R8 stopped after power-on");

    wr(3'b100, t0);
    quiet(9 * period(0, 0), "R3 R8 enable-one write does not start");

    for (int w = 0; w < 4; w++) begin
      wr(3'(w), t0);
      expiry(0, w, t0, "R4 main interval");
      if (w == 0) quiet(9 * period(0, 0), "R6 stopped after expiry");
    end

    use_sub = 1'b1;
    for (int w = 0; w < 4; w++) begin
      wr(3'(w), t0);
      expiry(1, w, t0, "R5 sub interval");
    end
    use_sub = 1'b0;

    wr(3'b000, t0);
    repeat (50) @(negedge clk);
    wr(3'b000, t1);
    expiry(0, 0, t1, "R3 restart timed from clear");

    wr(3'b001, t0);
    repeat (200) @(negedge clk);
    wr(3'b100, t1);
    expiry(0, 1, t0, "R3 enable-one write leaves count running");

    wr(3'b000, t0);
    repeat (30) @(negedge clk);
    wr(3'b011, t1);
    expiry(0, 0, t1, "R7 select frozen while running");

    wr(3'b000, t0);
    repeat (20) @(negedge clk);
    pulse(1, 0);
    chk(rdata == 8'hB7, "R9 external flag set others held", rdata, 8'hB7);
    quiet(9 * period(0, 0), "R9 external reset stops watchdog");

    wr(3'b000, t0);
    repeat (20) @(negedge clk);
    pulse(0, 1);
    chk(rdata == 8'hBF, "R10 software flag set others held", rdata, 8'hBF);
    quiet(9 * period(0, 0), "R10 software reset stops watchdog");
    wr(3'b000, t0);
    expiry(0, 0, t0, "R6 R10 start re-armed after reset");

    power_on();
    chk(rdata == 8'h87, "R11 flags cleared only by power-on", rdata, 8'h87);
    pulse(1, 1);
    chk(rdata == 8'h9F, "R10 simultaneous causes recorded", rdata, 8'h9F);
    @(negedge clk);
    ext_rst = 1'b1;
    por_n = 1'b0;
    @(negedge clk);
    ext_rst = 1'b0;
    por_n = 1'b1;
    @(negedge clk);
    chk(rdata == 8'h87, "R11 power-on overrides other cause", rdata, 8'h87);

    for (int i = 0; i < 12; i++) begin
      bit us;
      int w, p;
      us = 1'($urandom % 2);
      w = us ? int'($urandom % 4) : int'($urandom % 3);
      p = period(us, w);
      use_sub = us;
      wr(3'(w), t0);
      if ($urandom % 2) begin
        repeat (1 + ($urandom % (6 * p))) @(negedge clk);
        wr(3'(3 - w), t0);
      end
      expiry(us, w, t0, us ? "R5 random sub run" : "R4 random main run");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule